// File: doc/BRIEF.md
# SPI Control and Status Register

This block holds the 8-bit control and status word of an SPI port that can run as master or slave. Software reaches it through a single-cycle write strobe and a continuous read value. The shift engine, clock divider and data buffers stay outside. They report to this block through one-cycle strobes: transfer start, transfer done, receive character ready, buffer read and buffer write. They also supply the raw slave-select pin.

The block tracks transfer activity and keeps four sticky event flags: completion, receive overrun, write collision and mode fault. It decides whether a buffer write or a receive-buffer load may go ahead. It watches slave-select for a falling edge while acting as master and takes the port out of master mode when that edge is seen. It raises one interrupt line from the four flags.

Bit map of the register, MSB first: 7 busy, 6 done flag, 5 overrun flag, 4 collision flag, 3 fault flag, 2 fault-detect enable, 1 master select, 0 port enable.

Top module: `spi_ctl_regs`

## Requirements
- R1: After reset the register reads 0x00 and `irq_o` is 0.
- R2: Bit 7 (busy) reads 1 from the clock after `xfer_start_i` until the clock after `xfer_done_i`. Software writes to bit 7 have no effect.
- R3: Bit 6 (done flag) is set on the clock after `xfer_done_i`. Only hardware can set it.
- R4: Bits 6..3 are sticky. A register write with a 0 in a flag's position clears that flag. A 1 in that position leaves it unchanged. When a hardware set and a software clear land in the same cycle, the flag ends up set.
- R5: The block tracks one receive buffer, which is full from a load until a `buf_rd_i`. `rx_ready_i` while the buffer is full and not read in the same cycle gives `rx_load_o`=0 and sets bit 5 (overrun). Otherwise `rx_load_o` equals `rx_ready_i`.
- R6: `buf_wr_i` while busy is 1 gives `buf_wr_ok_o`=0 and sets bit 4 (collision). While idle, `buf_wr_ok_o` equals `buf_wr_i` and bit 4 is untouched.
- R7: Bit 1 (master select) and bit 2 (fault-detect enable) can both be 1 when slave-select falls. The fall is seen after a two-flop synchronizer. Three clocks after the pin falls, bit 3 (fault flag) is 1 and bit 1 is 0. With bit 2 or bit 1 at 0, bit 3 stays 0.
- R8: A write can raise bit 1 from 0 to 1 only while the synchronized slave-select is high. At other times that bit of the write is ignored. Writing 0 to bit 1 always clears it.
- R9: `irq_o` is `irq_en_i` AND the OR of bits 6..3.
- R10: Bits 2 and 0 are plain read/write control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| xfer_start_i | input | 1 | Transfer start strobe |
| xfer_done_i | input | 1 | Transfer done strobe |
| rx_ready_i | input | 1 | Received character ready strobe |
| buf_rd_i | input | 1 | Receive buffer read strobe |
| buf_wr_i | input | 1 | Transmit buffer write attempt |
| ss_n_i | input | 1 | Raw slave-select pin, active low |
| irq_en_i | input | 1 | Interrupt enable |
| buf_wr_ok_o | output | 1 | Buffer write allowed |
| rx_load_o | output | 1 | Receive buffer load allowed |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `xfer_start_i` and `xfer_done_i` never pulse in the same cycle. They also assume that every strobe is a single-cycle, clock-synchronous pulse, and that only the raw slave-select pin is asynchronous. The stimulus keeps to this by driving at most one transfer strobe per cycle and changing every input on the falling clock edge. It also waits three clocks after each slave-select change before it checks or writes, so the synchronizer has settled.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int REG_W    = 8;
  localparam int N_FLAGS  = 4;
  localparam int SYNC_STG = 2;
  // bit positions decoded by software
  localparam int B_BUSY  = 7;
  localparam int B_DONE  = 6;
  localparam int B_OVR   = 5;
  localparam int B_COL   = 4;
  localparam int B_FLT   = 3;
  localparam int B_FLTEN = 2;
  localparam int B_MST   = 1;
  localparam int B_EN    = 0;
  localparam int FLAG_LSB = B_FLT;
  // index within the flag vector
  typedef enum int {FI_FLT = 0, FI_COL = 1, FI_OVR = 2, FI_DONE = 3} flag_idx_e;
endpackage

// File: rtl/spi_sticky_flags.sv
module spi_sticky_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hw_set_i,
  input  logic [N-1:0] sw_clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q_o[i] <= 1'b0;
      else if (hw_set_i[i]) q_o[i] <= 1'b1;  // hardware wins
      else if (sw_clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ss_n_i,
  output logic ss_n_sync_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], ss_n_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign ss_n_sync_o = pipe_q[STAGES-1];
  assign fall_o      = prev_q & ~pipe_q[STAGES-1];
endmodule

// File: rtl/spi_rx_track.sv
module spi_rx_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_ready_i,
  input  logic buf_rd_i,
  output logic rx_load_o,
  output logic overrun_o
);
  logic full_q;

  assign rx_load_o = rx_ready_i & (~full_q | buf_rd_i);
  assign overrun_o = rx_ready_i & full_q & ~buf_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else         full_q <= (full_q & ~buf_rd_i) | rx_load_o;
  end
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
  import spi_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             xfer_start_i,
  input  logic             xfer_done_i,
  input  logic             rx_ready_i,
  input  logic             buf_rd_i,
  input  logic             buf_wr_i,
  input  logic             ss_n_i,
  input  logic             irq_en_i,
  output logic             buf_wr_ok_o,
  output logic             rx_load_o,
  output logic             irq_o
);
  logic               busy_q, flten_q, mst_q, en_q;
  logic               ss_n_sync, ss_fall, overrun, fault;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flags;

  spi_ss_sync #(.STAGES(SYNC_STG)) u_ss_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ss_n_i      (ss_n_i),
    .ss_n_sync_o (ss_n_sync),
    .fall_o      (ss_fall)
  );

  spi_rx_track u_rx_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_ready_i (rx_ready_i),
    .buf_rd_i   (buf_rd_i),
    .rx_load_o  (rx_load_o),
    .overrun_o  (overrun)
  );

  assign fault       = mst_q & flten_q & ss_fall;
  assign buf_wr_ok_o = buf_wr_i & ~busy_q;

  always_comb begin
    flag_set           = '0;
    flag_set[FI_DONE]  = xfer_done_i;
    flag_set[FI_OVR]   = overrun;
    flag_set[FI_COL]   = buf_wr_i & busy_q;
    flag_set[FI_FLT]   = fault;
    flag_clr           = {N_FLAGS{reg_we_i}} & ~reg_wdata_i[FLAG_LSB +: N_FLAGS];
  end

  spi_sticky_flags #(.N(N_FLAGS)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_set_i (flag_set),
    .sw_clr_i (flag_clr),
    .q_o      (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           busy_q <= 1'b0;
    else if (xfer_start_i) busy_q <= 1'b1;
    else if (xfer_done_i)  busy_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flten_q <= 1'b0;
      en_q    <= 1'b0;
    end else if (reg_we_i) begin
      flten_q <= reg_wdata_i[B_FLTEN];
      en_q    <= reg_wdata_i[B_EN];
    end
  end

  // master select: fault clear beats software; 0->1 gated by deasserted select
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mst_q <= 1'b0;
    else if (fault)  mst_q <= 1'b0;
    else if (reg_we_i) begin
      if (reg_wdata_i[B_MST] && !mst_q) mst_q <= ss_n_sync;
      else                              mst_q <= reg_wdata_i[B_MST];
    end
  end

  assign reg_rdata_o = {busy_q, flags, flten_q, mst_q, en_q};
  assign irq_o       = irq_en_i & (|flags);
endmodule

// File: rtl/spi_ctl_regs_chk.sv
module spi_ctl_regs_chk
  import spi_ctl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] rdata_i,
  input logic             xfer_start_i,
  input logic             xfer_done_i,
  input logic             rx_ready_i,
  input logic             buf_wr_i,
  input logic             irq_en_i,
  input logic             buf_wr_ok_i,
  input logic             rx_load_i,
  input logic             irq_i
);
  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_i |=> rdata_i[B_BUSY]);

  a_r3_done_hw_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdata_i[B_DONE] && !xfer_done_i) |=> !rdata_i[B_DONE]);

  a_r5_overrun_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ready_i && !rx_load_i) |=> rdata_i[B_OVR]);

  a_r6_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i[B_BUSY] && buf_wr_i) |-> !buf_wr_ok_i);

  a_r6_collision_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i[B_BUSY] && buf_wr_i) |=> rdata_i[B_COL]);

  a_r7_fault_drops_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_i[B_FLT]) |-> !rdata_i[B_MST]);

  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_i);
endmodule

bind spi_ctl_regs spi_ctl_regs_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rdata_i      (reg_rdata_o),
  .xfer_start_i (xfer_start_i),
  .xfer_done_i  (xfer_done_i),
  .rx_ready_i   (rx_ready_i),
  .buf_wr_i     (buf_wr_i),
  .irq_en_i     (irq_en_i),
  .buf_wr_ok_i  (buf_wr_ok_o),
  .rx_load_i    (rx_load_o),
  .irq_i        (irq_o)
);

// File: tb/spi_ctl_regs_bench.sv
`timescale 1ns/1ps
module spi_ctl_regs_bench;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       reg_we_i = 0, xfer_start_i = 0, xfer_done_i = 0;
  logic       rx_ready_i = 0, buf_rd_i = 0, buf_wr_i = 0;
  logic       ss_n_i = 1'b1, irq_en_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00, reg_rdata_o;
  logic       buf_wr_ok_o, rx_load_o, irq_o;
  int         vectors = 0, errors = 0;
  bit         done = 0;

  always #2.5 clk_i = ~clk_i;

  spi_ctl_regs u_spi_ctl_regs (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // drive one cycle of strobes at the falling edge; comb outputs valid after #1
  task automatic apply(input logic s, d, rr, rd, wr, we, input logic [7:0] wd);
    @(negedge clk_i);
    xfer_start_i = s; xfer_done_i = d; rx_ready_i = rr; buf_rd_i = rd;
    buf_wr_i = wr; reg_we_i = we; reg_wdata_i = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    xfer_start_i = 0; xfer_done_i = 0; rx_ready_i = 0; buf_rd_i = 0;
    buf_wr_i = 0; reg_we_i = 0;
  endtask

  task automatic wr_reg(input logic [7:0] wd);
    apply(0, 0, 0, 0, 0, 1, wd);
    idle();
  endtask

  task automatic set_ss(input logic v);
    @(negedge clk_i);
    ss_n_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(reg_rdata_o, 8'h00, "R1 rdata");
    chk({7'd0, irq_o}, 8'h00, "R1 irq");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(reg_rdata_o, 8'h00, "R1 rdata after release");

    // R4 R8 R10 full write sweep, select high: flags never set by writes
    for (int v = 0; v < 256; v++) begin
      wr_reg(8'(v));
      chk(reg_rdata_o, 8'(v) & 8'h07, "R4/R8/R10 sweep select high");
    end
    // R8 sweep with select low: master bit cannot rise
    wr_reg(8'h00);
    set_ss(1'b0);
    for (int v = 0; v < 256; v++) begin
      wr_reg(8'(v));
      chk(reg_rdata_o, 8'(v) & 8'h05, "R8 sweep select low");
    end
    wr_reg(8'h00);
    set_ss(1'b1);

    // R7 fault: master + enable, select falls
    wr_reg(8'h07);
    chk(reg_rdata_o, 8'h07, "R8 master set while high");
    set_ss(1'b0);
    chk(reg_rdata_o, 8'h0D, "R7 fault sets flag, drops master");
    irq_en_i = 1'b1; #1;
    chk({7'd0, irq_o}, 8'h01, "R9 irq from fault");
    irq_en_i = 1'b0; #1;
    chk({7'd0, irq_o}, 8'h00, "R9 irq gated");
    wr_reg(8'h05);
    chk(reg_rdata_o, 8'h05, "R4 fault flag cleared");
    set_ss(1'b1);
    // R7 no fault when detect disabled
    wr_reg(8'h03);
    set_ss(1'b0);
    chk(reg_rdata_o, 8'h03, "R7 no fault with detect off");
    wr_reg(8'h01);
    set_ss(1'b1);

    // R2 R6 busy and collision
    apply(1, 0, 0, 0, 0, 0, 8'h00); idle();
    chk(reg_rdata_o, 8'h81, "R2 busy set");
    apply(0, 0, 0, 0, 1, 0, 8'h00);
    chk({7'd0, buf_wr_ok_o}, 8'h00, "R6 write blocked");
    idle();
    chk(reg_rdata_o, 8'h91, "R6 collision flag");
    wr_reg(8'h01);
    chk(reg_rdata_o, 8'h81, "R2 busy not software clearable");
    apply(0, 1, 0, 0, 0, 0, 8'h00); idle();
    chk(reg_rdata_o, 8'h41, "R2/R3 busy cleared, done set");
    irq_en_i = 1'b1; #1;
    chk({7'd0, irq_o}, 8'h01, "R9 irq from done");
    apply(0, 0, 0, 0, 1, 0, 8'h00);
    chk({7'd0, buf_wr_ok_o}, 8'h01, "R6 write allowed idle");
    idle();
    chk(reg_rdata_o, 8'h41, "R6 no collision idle");
    wr_reg(8'hFF);
    chk(reg_rdata_o, 8'h47, "R2 write 1 to busy ignored");
    wr_reg(8'h01);
    // R4 hardware set beats software clear
    apply(0, 1, 0, 0, 0, 1, 8'h01); idle();
    chk(reg_rdata_o, 8'h41, "R4 set wins over clear");
    wr_reg(8'h01);
    chk(reg_rdata_o, 8'h01, "R4 done cleared");
    chk({7'd0, irq_o}, 8'h00, "R9 irq low with no flags");

    // R5 receive overrun
    apply(0, 0, 1, 0, 0, 0, 8'h00);
    chk({7'd0, rx_load_o}, 8'h01, "R5 first load");
    idle();
    chk(reg_rdata_o, 8'h01, "R5 no overrun");
    apply(0, 0, 1, 0, 0, 0, 8'h00);
    chk({7'd0, rx_load_o}, 8'h00, "R5 load refused when full");
    idle();
    chk(reg_rdata_o, 8'h21, "R5 overrun flag");
    wr_reg(8'h01);
    apply(0, 0, 1, 1, 0, 0, 8'h00);
    chk({7'd0, rx_load_o}, 8'h01, "R5 read and load same cycle");
    idle();
    chk(reg_rdata_o, 8'h01, "R5 no overrun on same-cycle read");
    apply(0, 0, 0, 1, 0, 0, 8'h00); idle();
    apply(0, 0, 1, 0, 0, 0, 8'h00);
    chk({7'd0, rx_load_o}, 8'h01, "R5 load after read");
    idle();
    chk(reg_rdata_o, 8'h01, "R5 flag stays clear");

    done = 1;
    summary();
  end
endmodule